// File: doc/BRIEF.md
# Saturating Connection Timeout Timer

This block measures, in milliseconds, how long a charger-detection sequence has been running, so that the whole sequence can be held to a one-second compliance budget. Software supplies an initial latency value that accounts for time already spent before the sequence was started. When a start request is accepted, the elapsed-time count is loaded with that latency. From then on it advances by one on every millisecond tick while the sequence reports itself active.

The count never wraps: it stops at its all-ones value. Counting goes on after the sequence has handed control to software, for as long as the active input stays high. The first time the count reaches one thousand, the block raises a sticky timeout flag and a sticky interrupt request, and emits a single-cycle error pulse. A software reset returns everything to the idle state and makes a new start possible.

Top module: `conn_tmo_timer`

## Requirements
- R1: After the asynchronous reset is released, `countMs` is 0 and `tmoFlag`, `irqReq` and `errPulse` are all 0.
- R2: A `startReq` seen while the timer is idle is accepted. In the next cycle `countMs` equals `preloadMs`, zero-extended to 12 bits, and no tick counts in the cycle of acceptance.
- R3: A `startReq` seen while a run is already in progress has no effect: `countMs` keeps its value and is not reloaded.
- R4: During a run, a cycle with both `seqActive` and `msTick` high raises `countMs` by exactly one in the next cycle.
- R5: When `seqActive` is low, when `msTick` is low, or when no run is in progress, `countMs` holds its value.
- R6: `countMs` saturates at 4095. A tick at 4095 leaves it at 4095, and it never returns to a smaller value except through a load or a software reset.
- R7: On the first counted tick whose resulting count is 1000 or more, `tmoFlag` and `irqReq` go high in the next cycle. Both stay high until a software reset.
- R8: `errPulse` is high for exactly one cycle: the cycle in which `tmoFlag` first rises. It does not pulse again during the same run.
- R9: A `swReset` cycle clears `countMs`, `tmoFlag`, `irqReq`, `errPulse` and the run state in the next cycle. It takes priority over a `startReq` or a tick in the same cycle.
- R10: After the timeout has been raised, counting continues while `seqActive` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to begin a timed run |
| seqActive | input | 1 | The detection sequence is active; counting is enabled |
| swReset | input | 1 | Synchronous software reset |
| msTick | input | 1 | One-cycle pulse once per millisecond |
| preloadMs | input | 10 | Latency preload in ms (0 to 1023) |
| countMs | output | 12 | Elapsed time in ms (read-only) |
| tmoFlag | output | 1 | Sticky timeout flag |
| errPulse | output | 1 | Single-cycle error strobe when the timeout is raised |
| irqReq | output | 1 | Sticky interrupt request |

## Verification
Two cases are the hardest to reach from the ports. The first is saturation at 4095, which needs thousands of counted ticks in a single run without a reset. The second is the timeout crossing with a large preload, where the very first tick already lands at or beyond 1000. Directed phases start runs with preloads of 995 and 1023, then deliver an unbroken stream of ticks past the limit and on up to saturation. The random phase biases its preloads toward the region just below 1000, so that crossings, starts during a run and software resets coincide often.

// File: rtl/cto_pkg.sv
package cto_pkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clear;  // software reset: zero the count
    logic load;   // accepted start: take the preload
    logic inc;    // counted millisecond tick
  } cto_strobe_t;
endpackage

// File: rtl/cto_datapath.sv
module cto_datapath
  import cto_pkg::*;
#(
  parameter int PRELOAD_W = 10,
  parameter int COUNT_W   = 12,
  parameter int LIMIT_MS  = 1000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cto_strobe_t          strb,
  input  logic [PRELOAD_W-1:0] preloadMs,
  output logic [COUNT_W-1:0]   countMs,
  output logic                 reachNext
);
  localparam logic [COUNT_W-1:0] CountMax = {COUNT_W{1'b1}};
  localparam logic [COUNT_W-1:0] LimitVal = COUNT_W'(LIMIT_MS);
  localparam int                 PadW     = COUNT_W - PRELOAD_W;

  logic [COUNT_W-1:0] cntQ;
  logic [COUNT_W-1:0] incVal;
  logic [COUNT_W-1:0] loadVal;

  always_comb begin
    loadVal = {{PadW{1'b0}}, preloadMs};
    if (cntQ == CountMax) incVal = cntQ;
    else                  incVal = cntQ + 1'b1;
    reachNext = (incVal >= LimitVal);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cntQ <= '0;
    else if (strb.clear) cntQ <= '0;
    else if (strb.load)  cntQ <= loadVal;
    else if (strb.inc)   cntQ <= incVal;
  end

  assign countMs = cntQ;

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ == CountMax && !strb.clear && !strb.load) |=> (cntQ == CountMax)); // R6
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clear && !strb.load) |=> (cntQ >= $past(cntQ))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clear && !strb.load && !strb.inc) |=> $stable(cntQ)); // R5
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (cntQ == '0)); // R9
endmodule

// File: rtl/cto_ctrl.sv
module cto_ctrl
  import cto_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        seqActive,
  input  logic        swReset,
  input  logic        msTick,
  input  logic        reachNext,
  output cto_strobe_t strb,
  output logic        tmoFlag,
  output logic        errPulse,
  output logic        irqReq
);
  logic runQ;
  logic tmoQ;
  logic irqQ;
  logic errQ;
  logic raise;

  always_comb begin
    strb.clear = swReset;
    strb.load  = !swReset && startReq && !runQ;
    strb.inc   = !swReset && runQ && seqActive && msTick;
    raise      = strb.inc && reachNext && !tmoQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ <= 1'b0;
      tmoQ <= 1'b0;
      irqQ <= 1'b0;
      errQ <= 1'b0;
    end else if (swReset) begin
      runQ <= 1'b0;
      tmoQ <= 1'b0;
      irqQ <= 1'b0;
      errQ <= 1'b0;
    end else begin
      if (strb.load) runQ <= 1'b1;
      errQ <= raise;
      if (raise) begin
        tmoQ <= 1'b1;
        irqQ <= 1'b1;
      end
    end
  end

  assign tmoFlag  = tmoQ;
  assign irqReq   = irqQ;
  assign errPulse = errQ;

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    errQ |=> !errQ); // R8
  AST_ERR_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tmoQ) |-> errQ); // R8
  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (tmoQ && !swReset) |=> (tmoQ && irqQ)); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && !swReset) |-> !strb.load); // R3
endmodule

// File: rtl/conn_tmo_timer.sv
module conn_tmo_timer
  import cto_pkg::*;
#(
  parameter int PRELOAD_W = 10,
  parameter int COUNT_W   = 12,
  parameter int LIMIT_MS  = 1000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic                 seqActive,
  input  logic                 swReset,
  input  logic                 msTick,
  input  logic [PRELOAD_W-1:0] preloadMs,
  output logic [COUNT_W-1:0]   countMs,
  output logic                 tmoFlag,
  output logic                 errPulse,
  output logic                 irqReq
);
  cto_strobe_t strb;
  logic        reachNext;

  cto_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .seqActive (seqActive),
    .swReset   (swReset),
    .msTick    (msTick),
    .reachNext (reachNext),
    .strb      (strb),
    .tmoFlag   (tmoFlag),
    .errPulse  (errPulse),
    .irqReq    (irqReq)
  );

  cto_datapath #(
    .PRELOAD_W (PRELOAD_W),
    .COUNT_W   (COUNT_W),
    .LIMIT_MS  (LIMIT_MS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .preloadMs (preloadMs),
    .countMs   (countMs),
    .reachNext (reachNext)
  );
endmodule

// File: tb/conn_tmo_timer_bench.sv
module conn_tmo_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        seqActive = 1'b0;
  logic        swReset = 1'b0;
  logic        msTick = 1'b0;
  logic [9:0]  preloadMs = '0;
  logic [11:0] countMs;
  logic        tmoFlag;
  logic        errPulse;
  logic        irqReq;

  int total = 0;
  int bad = 0;

  // reference state
  bit      mRun, mTmo, mIrq, mErr;
  int      mCnt;

  always #4 clk = ~clk;

  conn_tmo_timer u_conn_tmo_timer (
    .clk(clk), .rstN(rstN), .startReq(startReq), .seqActive(seqActive),
    .swReset(swReset), .msTick(msTick), .preloadMs(preloadMs),
    .countMs(countMs), .tmoFlag(tmoFlag), .errPulse(errPulse), .irqReq(irqReq)
  );

  function automatic int satInc(int v);
    return (v >= 4095) ? 4095 : v + 1;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic chkAll(string tag);
    chk(tag, "countMs", int'(countMs), mCnt);
    chk(tag, "tmoFlag", int'(tmoFlag), int'(mTmo));
    chk(tag, "irqReq", int'(irqReq), int'(mIrq));
    chk(tag, "errPulse", int'(errPulse), int'(mErr));
  endtask

  task automatic step(string tag, bit st, bit act, bit sr, bit tk, int pl);
    int nxt;
    startReq = st; seqActive = act; swReset = sr; msTick = tk;
    preloadMs = 10'(pl);
    if (sr) begin
      mRun = 0; mCnt = 0; mTmo = 0; mIrq = 0; mErr = 0;
    end else begin
      mErr = 0;
      if (st && !mRun) begin
        mRun = 1; mCnt = pl;
      end else if (mRun && act && tk) begin
        nxt = satInc(mCnt);
        if (nxt >= 1000 && !mTmo) begin
          mTmo = 1; mIrq = 1; mErr = 1;
        end
        mCnt = nxt;
      end
    end
    @(posedge clk); #1;
    chkAll(tag);
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5a17);
    mRun = 0; mCnt = 0; mTmo = 0; mIrq = 0; mErr = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    chkAll("R1");

    // R2: start with preload 7, then R4 ticks
    step("R2", 1, 1, 0, 1, 7);
    chk("R2", "load", int'(countMs), 7);
    step("R4", 0, 1, 0, 1, 0);
    chk("R4", "inc", int'(countMs), 8);
    // R3: start while running does not reload
    step("R3", 1, 1, 0, 0, 500);
    chk("R3", "noReload", int'(countMs), 8);
    // R5: inactive holds, no tick holds
    for (int i = 0; i < 5; i++) step("R5", 0, 0, 0, 1, 0);
    chk("R5", "hold", int'(countMs), 8);
    // R9: reset beats start and tick
    step("R9", 1, 1, 1, 1, 300);
    chk("R9", "clear", int'(countMs), 0);
    // R5: idle ticks do nothing
    for (int i = 0; i < 4; i++) step("R5", 0, 1, 0, 1, 0);
    chk("R5", "idleHold", int'(countMs), 0);

    // R7/R8: preload 995, cross at 1000
    step("R2", 1, 0, 0, 0, 995);
    for (int i = 0; i < 4; i++) step("R7", 0, 1, 0, 1, 0);
    chk("R7", "notYet", int'(tmoFlag), 0);
    step("R7", 0, 1, 0, 1, 0);
    chk("R7", "tmoAt1000", int'(tmoFlag), 1);
    chk("R8", "errPulse", int'(errPulse), 1);
    step("R8", 0, 1, 0, 1, 0);
    chk("R8", "errDrop", int'(errPulse), 0);
    chk("R10", "keepsCounting", int'(countMs), 1001);
    step("R9", 0, 0, 1, 0, 0);
    chk("R9", "tmoCleared", int'(tmoFlag), 0);

    // R7 with preload 1023: first tick raises; then R6 saturation
    step("R2", 1, 1, 0, 0, 1023);
    step("R7", 0, 1, 0, 1, 0);
    chk("R7", "firstTick", int'(irqReq), 1);
    for (int i = 0; i < 3075; i++) step("R6", 0, 1, 0, 1, 0);
    chk("R6", "saturate", int'(countMs), 4095);
    chk("R8", "noRepeat", int'(errPulse), 0);
    step("R9", 0, 0, 1, 0, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit st, act, sr, tk;
      int pl;
      st  = ($urandom % 8) == 0;
      act = ($urandom % 4) != 0;
      sr  = ($urandom % 300) == 0;
      tk  = ($urandom % 2) == 0;
      pl  = (($urandom % 2) == 0) ? 960 + int'($urandom % 64) : int'($urandom % 1024);
      step("R4", st, act, sr, tk, pl);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule